// File: doc/BRIEF.md
# Outstanding Read Ordering Scheduler

This block sits between a memory-mapped request port and a bus-side issue port. Requests on the request port are reads or writes. Each one carries an address, a burst length of 1 to 16 beats and an address-space code for memory, I/O or configuration. The block caps the number of reads in flight on the bus, and a parameter sets the cap at one or four. Reads that cannot go out yet wait in an eight-entry queue and leave it in arrival order.

A write sits in a one-entry slot and goes out ahead of any reads that are still queued. The request port accepts nothing while the read queue is full, so no write is taken in behind a read that had nowhere to go. Every issued read takes a 2-bit tag from a pool of free tags. A completion pulse that carries that tag puts it back in the pool and frees one in-flight slot. The block also reports how full the queue is and how many reads are in flight.

Top module: `rd_order_sched`

## Requirements
- R1: After reset the queue is empty (`q_count` = 0), no reads are in flight (`inflight` = 0), `out_valid` is low and `in_ready` is high.
- R2: When `MULTI_RD` = 0, at most one read is in flight. A second read waits in the queue until a completion with the busy tag arrives.
- R3: When `MULTI_RD` = 1, up to four reads are in flight at once. A fifth read waits in the queue until a completion frees a tag.
- R4: The read queue holds up to 8 requests, and `q_count` reports how many it holds. A read that is being presented on the issue port but has not been accepted still counts in the queue.
- R5: While `q_count` = 8, `in_ready` is low for reads and for writes alike, and no request is accepted.
- R6: A write that arrives while reads are waiting in the queue is issued before those reads, and the queue contents do not change.
- R7: An issued read carries the lowest-numbered free tag (tags 0..3). Each accepted read raises `inflight` by one. A completion (`cpl_valid` high with `cpl_tag` = the tag) lowers `inflight` by one and returns the tag to the pool.
- R8: Queued reads are issued in the order they arrived.
- R9: While `out_valid` is high and `out_ready` is low, all issue-port fields stay stable.
- R10: When a write is waiting and a queued read also has a free tag, the write is issued first.
- R11: Address, burst length (`len_m1` = length − 1, 4 bits), space code (0 = memory, 1 = I/O, 2 = configuration) and direction (`is_write` = 1 for a write) pass from the request port to the issue port unchanged.
- R12: A completion whose tag is not in flight is ignored, and `inflight` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted on this edge when high with `in_valid` |
| in_addr | input | 32 | Request address |
| in_len_m1 | input | 4 | Burst length minus one |
| in_space | input | 2 | Space code: 0 memory, 1 I/O, 2 configuration |
| in_is_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Issue request valid |
| out_ready | input | 1 | Bus side accepts the issued request |
| out_addr | output | 32 | Issued address |
| out_len_m1 | output | 4 | Issued burst length minus one |
| out_space | output | 2 | Issued space code |
| out_is_write | output | 1 | Issued direction |
| out_tag | output | 2 | Tag of an issued read (0 for writes) |
| cpl_valid | input | 1 | Read completion pulse |
| cpl_tag | input | 2 | Tag of the completed read |
| q_count | output | 4 | Number of reads waiting in the queue |
| inflight | output | 3 | Number of reads in flight |

## Verification
Two things can become ready in the same cycle: a waiting write and a queued read whose tag has just been freed. The bench holds the issue port stalled with all tags busy while a write enters its slot. It then sends a completion, so that the head read becomes eligible in the cycle after. It checks that the port still offers the write, and that the accepted order is the write first and then the read carrying the freed tag. The same completion is sent to a single-read instance that does not have that tag in flight, and the bench checks that its in-flight count does not move.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;

    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 4;
    localparam int TAG_W    = 2;
    localparam int NUM_TAGS = 4;
    localparam int SPACE_W  = 2;

    typedef enum logic [SPACE_W-1:0] {
        SP_MEM = 2'd0,
        SP_IO  = 2'd1,
        SP_CFG = 2'd2
    } space_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len_m1;
        space_e            space;
        logic              is_wr;
    } req_t;

    localparam int REQ_W = $bits(req_t);

    function automatic req_t make_req(input logic [ADDR_W-1:0] a,
                                      input logic [LEN_W-1:0] l,
                                      input logic [SPACE_W-1:0] s,
                                      input logic w);
        req_t r;
        r.addr   = a;
        r.len_m1 = l;
        r.space  = space_e'(s);
        r.is_wr  = w;
        return r;
    endfunction

endpackage

// File: rtl/rdsched_fifo.sv
module rdsched_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rdsched_tagpool.sv
module rdsched_tagpool #(
    parameter int N   = 4,
    parameter int USE = 4,
    localparam int TW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic [TW-1:0] alloc_tag,
    input  logic          rel,
    input  logic [TW-1:0] rel_tag,
    output logic [TW-1:0] free_tag,
    output logic          any_free,
    output logic [CW-1:0] busy_cnt
);

    logic [N-1:0] busy, allowed, free_m, rel_m, alloc_m;

    for (genvar i = 0; i < N; i++) begin : g_allow
        assign allowed[i] = (i < USE);
    end

    assign free_m   = allowed & ~busy;
    assign any_free = |free_m;
    assign rel_m    = rel   ? (N'(1) << rel_tag)   : '0;
    assign alloc_m  = alloc ? (N'(1) << alloc_tag) : '0;
    assign busy_cnt = CW'($countones(busy));

    always_comb begin
        free_tag = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_m[i]) free_tag = TW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= (busy & ~rel_m) | alloc_m;
    end

endmodule

// File: rtl/rd_order_sched.sv
module rd_order_sched
    import rdsched_pkg::*;
#(
    parameter int MULTI_RD = 1,
    parameter int QDEPTH   = 8,
    localparam int MAX_RD  = (MULTI_RD != 0) ? NUM_TAGS : 1,
    localparam int QCW     = $clog2(QDEPTH + 1),
    localparam int IFW     = $clog2(NUM_TAGS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [LEN_W-1:0]   in_len_m1,
    input  logic [SPACE_W-1:0] in_space,
    input  logic               in_is_write,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [LEN_W-1:0]   out_len_m1,
    output logic [SPACE_W-1:0] out_space,
    output logic               out_is_write,
    output logic [TAG_W-1:0]   out_tag,
    input  logic               cpl_valid,
    input  logic [TAG_W-1:0]   cpl_tag,
    output logic [QCW-1:0]     q_count,
    output logic [IFW-1:0]     inflight
);

    req_t             in_req, wr_req, q_head, sel_req;
    logic [REQ_W-1:0] q_head_bits;
    logic             accept, q_full, q_empty, q_push, q_pop;
    logic             wr_pend, rd_hold, sel_wr, sel_rd, rd_fire, wr_fire;
    logic             any_free;
    logic [TAG_W-1:0] free_tag, held_tag;

    assign in_req   = make_req(in_addr, in_len_m1, in_space, in_is_write);
    assign in_ready = !q_full && !wr_pend;
    assign accept   = in_valid && in_ready;
    assign q_push   = accept && !in_is_write;

    rdsched_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_rdq (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (in_req),
        .pop       (q_pop),
        .head      (q_head_bits),
        .count     (q_count),
        .full      (q_full),
        .empty     (q_empty)
    );
    assign q_head = req_t'(q_head_bits);

    rdsched_tagpool #(.N(NUM_TAGS), .USE(MAX_RD)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .alloc     (rd_fire),
        .alloc_tag (out_tag),
        .rel       (cpl_valid),
        .rel_tag   (cpl_tag),
        .free_tag  (free_tag),
        .any_free  (any_free),
        .busy_cnt  (inflight)
    );

    // Issue select: a waiting write wins unless a read is already locked on the port.
    assign sel_wr  = wr_pend && !rd_hold;
    assign sel_rd  = !sel_wr && (rd_hold || (!q_empty && any_free));
    assign sel_req = sel_wr ? wr_req : q_head;

    assign out_valid    = sel_wr || sel_rd;
    assign out_addr     = sel_req.addr;
    assign out_len_m1   = sel_req.len_m1;
    assign out_space    = sel_req.space;
    assign out_is_write = sel_req.is_wr;
    assign out_tag      = sel_rd ? (rd_hold ? held_tag : free_tag) : '0;

    assign rd_fire = sel_rd && out_ready;
    assign wr_fire = sel_wr && out_ready;
    assign q_pop   = rd_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend  <= 1'b0;
            wr_req   <= '0;
            rd_hold  <= 1'b0;
            held_tag <= '0;
        end else begin
            if (accept && in_is_write) begin
                wr_pend <= 1'b1;
                wr_req  <= in_req;
            end else if (wr_fire) begin
                wr_pend <= 1'b0;
            end

            if (sel_rd && !out_ready) begin
                rd_hold  <= 1'b1;
                held_tag <= out_tag;
            end else if (rd_fire) begin
                rd_hold  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rdsched_chk.sv
module rdsched_chk #(
    parameter int MULTI_RD = 1,
    parameter int QDEPTH   = 8,
    parameter int QCW      = 4,
    parameter int IFW      = 3,
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 4,
    parameter int TAG_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [LEN_W-1:0]  out_len_m1,
    input logic              out_is_write,
    input logic [TAG_W-1:0]  out_tag,
    input logic              cpl_valid,
    input logic [QCW-1:0]    q_count,
    input logic [IFW-1:0]    inflight
);

    localparam logic [IFW-1:0] CAP  = (MULTI_RD != 0) ? IFW'(4) : IFW'(1);
    localparam logic [QCW-1:0] QCAP = QCW'(QDEPTH);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (q_count == '0 && inflight == '0 && !out_valid));

    // R2 R3
    inflight_cap_chk: assert property (@(posedge clk) disable iff (rst)
        inflight <= CAP);

    // R4
    q_cap_chk: assert property (@(posedge clk) disable iff (rst)
        q_count <= QCAP);

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (q_count == QCAP) |-> !in_ready);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
            $stable(out_len_m1) && $stable(out_is_write) && $stable(out_tag)));

    // R7
    rd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_write) |-> (inflight < CAP));

    // R7
    rd_count_up_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_is_write && !cpl_valid)
            |=> (inflight == $past(inflight) + 1'b1));

endmodule

bind rd_order_sched rdsched_chk #(
    .MULTI_RD (MULTI_RD),
    .QDEPTH   (QDEPTH),
    .QCW      (QCW),
    .IFW      (IFW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_addr     (out_addr),
    .out_len_m1   (out_len_m1),
    .out_is_write (out_is_write),
    .out_tag      (out_tag),
    .cpl_valid    (cpl_valid),
    .q_count      (q_count),
    .inflight     (inflight)
);

// File: tb/rd_order_sched_bench.sv
`timescale 1ns/1ps
module rd_order_sched_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_is_write = 1'b0, out_ready = 1'b0;
    logic [31:0] in_addr = '0;
    logic [3:0]  in_len_m1 = '0;
    logic [1:0]  in_space = '0;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_tag = '0;

    logic        a_in_ready, a_out_valid, a_out_is_write;
    logic [31:0] a_out_addr;
    logic [3:0]  a_out_len, a_q;
    logic [1:0]  a_out_space, a_out_tag;
    logic [2:0]  a_inf;

    logic        b_in_ready, b_out_valid, b_out_is_write;
    logic [31:0] b_out_addr;
    logic [3:0]  b_out_len, b_q;
    logic [1:0]  b_out_space, b_out_tag;
    logic [2:0]  b_inf;

    int n_chk = 0, n_fail = 0;
    int na = 0, nb = 0;
    logic [31:0] la_addr [32];
    logic [1:0]  la_tag  [32];
    logic        la_wr   [32];
    logic [3:0]  la_len  [32];
    logic [1:0]  la_sp   [32];
    logic [31:0] lb_addr [32];

    always #2 clk = ~clk;

    rd_order_sched #(.MULTI_RD(1)) u_rd_order_sched (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(a_in_ready),
        .in_addr(in_addr), .in_len_m1(in_len_m1), .in_space(in_space),
        .in_is_write(in_is_write), .out_valid(a_out_valid), .out_ready(out_ready),
        .out_addr(a_out_addr), .out_len_m1(a_out_len), .out_space(a_out_space),
        .out_is_write(a_out_is_write), .out_tag(a_out_tag), .cpl_valid(cpl_valid),
        .cpl_tag(cpl_tag), .q_count(a_q), .inflight(a_inf));

    rd_order_sched #(.MULTI_RD(0)) u_rd_order_sched_single (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_in_ready),
        .in_addr(in_addr), .in_len_m1(in_len_m1), .in_space(in_space),
        .in_is_write(in_is_write), .out_valid(b_out_valid), .out_ready(out_ready),
        .out_addr(b_out_addr), .out_len_m1(b_out_len), .out_space(b_out_space),
        .out_is_write(b_out_is_write), .out_tag(b_out_tag), .cpl_valid(cpl_valid),
        .cpl_tag(cpl_tag), .q_count(b_q), .inflight(b_inf));

    // Issue monitor: a request seen valid and ready at the negedge is taken at the next edge.
    always @(negedge clk) begin
        if (rst) begin
            na = 0;
            nb = 0;
        end else begin
            if (a_out_valid && out_ready && na < 32) begin
                la_addr[na] = a_out_addr; la_tag[na] = a_out_tag;
                la_wr[na] = a_out_is_write; la_len[na] = a_out_len; la_sp[na] = a_out_space;
                na++;
            end
            if (b_out_valid && out_ready && nb < 32) begin
                lb_addr[nb] = b_out_addr;
                nb++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; in_valid = 1'b0; in_is_write = 1'b0;
        out_ready = 1'b0; cpl_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic push(input logic [31:0] a, input logic [3:0] l,
                        input logic [1:0] s, input logic w);
        @(posedge clk); #1;
        in_valid = 1'b1; in_addr = a; in_len_m1 = l; in_space = s; in_is_write = w;
        forever begin
            @(negedge clk);
            if (a_in_ready && b_in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic complete(input logic [1:0] t);
        @(posedge clk); #1;
        cpl_valid = 1'b1; cpl_tag = t;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "q_count", a_q, 0);
        chk("R1", "inflight", a_inf, 0);
        chk("R1", "out_valid", a_out_valid, 0);
        chk("R1", "in_ready", a_in_ready, 1);
    endtask

    task automatic t_caps();
        do_reset();
        @(posedge clk); #1 out_ready = 1'b1;
        push(32'h100, 4'd3, 2'd2, 1'b0);
        for (int i = 1; i < 5; i++) push(32'h100 + i, 4'd0, 2'd0, 1'b0);
        settle(4);
        chk("R3", "issued count", na, 4);
        chk("R3", "inflight", a_inf, 4);
        chk("R4", "q_count multi", a_q, 1);
        for (int i = 0; i < 4; i++) chk("R7", "tag order", la_tag[i], i);
        chk("R11", "read len", la_len[0], 3);
        chk("R11", "read space", la_sp[0], 2);
        chk("R11", "read dir", la_wr[0], 0);
        chk("R2", "single issued", nb, 1);
        chk("R2", "single inflight", b_inf, 1);
        chk("R2", "single q_count", b_q, 4);
        complete(2'd2);
        settle(3);
        chk("R7", "reissue count", na, 5);
        chk("R7", "reused tag", la_tag[4], 2);
        chk("R8", "fifth addr", la_addr[4], 32'h104);
        chk("R7", "inflight after reuse", a_inf, 4);
        chk("R12", "stray cpl single inflight", b_inf, 1);
        chk("R2", "single still one", nb, 1);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 8; i++) push(32'h200 + i, 4'd1, 2'd0, 1'b0);
        @(negedge clk);
        chk("R4", "q_count full", a_q, 8);
        chk("R5", "in_ready full", a_in_ready, 0);
        chk("R9", "held valid", a_out_valid, 1);
        chk("R9", "held addr", a_out_addr, 32'h200);
        @(posedge clk); #1;
        in_valid = 1'b1; in_is_write = 1'b1; in_addr = 32'h999;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5", "write stalled", a_in_ready, 0);
        end
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R5", "q_count unchanged", a_q, 8);
        chk("R9", "addr stable", a_out_addr, 32'h200);
        chk("R9", "tag stable", a_out_tag, 0);
        chk("R9", "dir stable", a_out_is_write, 0);
        @(posedge clk); #1 out_ready = 1'b1;
        settle(8);
        chk("R3", "issued after release", na, 4);
        for (int i = 0; i < 4; i++) chk("R8", "arrival order", la_addr[i], 32'h200 + i);
        chk("R4", "q_count after", a_q, 4);
        chk("R2", "single issued one", nb, 1);
        chk("R2", "single q_count", b_q, 7);
        chk("R8", "single head", lb_addr[0], 32'h200);
    endtask

    task automatic t_bypass();
        do_reset();
        @(posedge clk); #1 out_ready = 1'b1;
        for (int i = 0; i < 5; i++) push(32'h100 + i, 4'd0, 2'd0, 1'b0);
        settle(3);
        @(posedge clk); #1 out_ready = 1'b0;
        push(32'h900, 4'd15, 2'd1, 1'b1);
        complete(2'd1);
        settle(2);
        chk("R10", "write offered", a_out_valid, 1);
        chk("R10", "write first", a_out_is_write, 1);
        chk("R10", "write addr", a_out_addr, 32'h900);
        chk("R6", "read still queued", a_q, 1);
        chk("R7", "inflight after cpl", a_inf, 3);
        chk("R12", "single ignores tag1", b_inf, 1);
        @(posedge clk); #1 out_ready = 1'b1;
        settle(4);
        chk("R6", "issued total", na, 6);
        chk("R6", "write overtakes", la_wr[4], 1);
        chk("R11", "write addr", la_addr[4], 32'h900);
        chk("R11", "write len", la_len[4], 15);
        chk("R11", "write space", la_sp[4], 1);
        chk("R8", "read after write", la_addr[5], 32'h104);
        chk("R7", "freed tag used", la_tag[5], 1);
        chk("R6", "queue drained", a_q, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_caps();
                t_full();
                t_bypass();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog run did not finish");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule